// File: doc/BRIEF.md
# Superscalar Register Rename Stage with In-Group Forwarding

This block renames a group of up to four instructions per clock. Each slot carries its own valid bits, two architectural source numbers and one architectural destination. The stage maps the sources to physical tags using a directly indexed alias table. The table has one entry per architectural register, and each entry holds one physical tag. Each destination receives a fresh tag from an outside allocator port, and the stage reports the mapping that this destination displaces so that recovery logic can checkpoint it. All translations for the group are produced in the same cycle as combinational outputs. The new mappings enter the table at the next rising edge.

A source may be written by an older slot in the same group. Such a source takes that producer's fresh tag, and its table read is switched off, because the stored value would be thrown away. A 32-bit counter accumulates how many source reads were switched off this way.

A separate restore port lets recovery logic write one checkpointed tag back into one table entry. A restore takes the whole cycle: the stage raises a stall output, the rename group presented in that cycle is dropped, and nothing is counted.

Top module: `rename_stage`

## Requirements
- R1: After synchronous reset, table entry n holds physical tag n, the suppression counter reads 0 and stall is low.
- R2: A valid source in a valid slot with no older in-group producer receives the table mapping in the same cycle. Slot i uses bits [i*5 +: 5] of each architectural bus and bits [i*7 +: 7] of each tag bus, and slot 0 is the oldest. A source whose slot or source-valid bit is low outputs tag 0.
- R3: A valid source equal to the destination of an older valid slot with its destination-valid bit set receives that slot's free tag. When several older slots qualify, the nearest older one wins.
- R4: At the next rising edge, the suppression counter grows by the number of valid sources that had an in-group producer in that cycle. The counter wraps at 2^32.
- R5: For a valid slot with a valid destination, the checkpoint output gives the mapping that the slot displaces. This is the nearest older in-group writer's free tag if there is one, otherwise the table value. Otherwise the checkpoint output is 0.
- R6: At the rising edge, every destination in the group is written to the table. When several slots name the same destination, the youngest slot's tag is kept. Entries that no slot names keep their value.
- R7: While restore is requested, stall is high and the given entry is written with the given tag at the edge. In that cycle the rename group neither updates the table nor advances the counter.
- R8: A slot whose valid bit is low, or whose destination-valid bit is low, neither writes the table nor acts as an in-group producer for younger slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inst_vld | input | 4 | Slot valid, bit i for slot i |
| src0_vld | input | 4 | First source valid per slot |
| src1_vld | input | 4 | Second source valid per slot |
| dst_vld | input | 4 | Destination valid per slot |
| src0_arch | input | 20 | First source architectural numbers, 5 bits per slot |
| src1_arch | input | 20 | Second source architectural numbers |
| dst_arch | input | 20 | Destination architectural numbers |
| free_tag | input | 28 | Newly allocated physical tags, 7 bits per slot |
| rec_en | input | 1 | Restore request |
| rec_arch | input | 5 | Entry to restore |
| rec_tag | input | 7 | Tag written by the restore |
| src0_phys | output | 28 | Renamed first sources |
| src1_phys | output | 28 | Renamed second sources |
| old_phys | output | 28 | Displaced destination mappings for checkpointing |
| stall | output | 1 | High while a restore owns the stage |
| gated_reads | output | 32 | Running count of suppressed source reads |

## Verification
The first group has no dependencies inside it, so every source must come from the table; this separates plain lookup from forwarding. The second group chains writes to one register through three slots and reads it twice. This tells the nearest producer apart from an older one, checks that the checkpoint output shows an in-group tag rather than the table, and checks that the youngest writer is the one stored. The third group mixes invalid slots, invalid sources and an invalid destination, so a missing qualifier shows up as a wrong tag or a wrong count. The last groups read back the table after the updates and after a restore that had a competing rename in the same cycle.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int RN_WIDTH     = 4;
    localparam int RN_ARCH_REGS = 32;
    localparam int RN_PHYS_REGS = 128;
    localparam int RN_CNT_BITS  = 32;

    // Index width that stays at least one bit wide.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Source of a renamed operand.
    typedef enum logic [1:0] {
        OPND_NONE  = 2'd0,
        OPND_TABLE = 2'd1,
        OPND_FWD   = 2'd2
    } opnd_src_e;

endpackage

// File: rtl/rn_dep_check.sv
module rn_dep_check
    import rename_pkg::*;
#(
    parameter int W  = RN_WIDTH,
    parameter int AW = 5,
    localparam int IW = idx_bits(W)
) (
    input  logic [W-1:0]          prod_en,
    input  logic [W-1:0][AW-1:0]  prod_arch,
    input  logic [W-1:0]          cons_en,
    input  logic [W-1:0][AW-1:0]  cons_arch,
    output logic [W-1:0]          hit,
    output logic [W-1:0][IW-1:0]  prod_idx
);

    // Compare each consumer against all older producers. The later (nearer)
    // match overrides an earlier one, so the nearest producer is chosen.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            hit[i]      = 1'b0;
            prod_idx[i] = '0;
            for (int j = 0; j < W; j++) begin
                if (j < i && prod_en[j] && cons_en[i] &&
                    prod_arch[j] == cons_arch[i]) begin
                    hit[i]      = 1'b1;
                    prod_idx[i] = IW'(j);
                end
            end
        end
    end

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rename_pkg::*;
#(
    parameter int W      = RN_WIDTH,
    parameter int ARCH_N = RN_ARCH_REGS,
    parameter int PHYS_N = RN_PHYS_REGS,
    localparam int AW = idx_bits(ARCH_N),
    localparam int PW = idx_bits(PHYS_N),
    localparam int RP = 3 * W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [RP-1:0]          rd_en,
    input  logic [RP-1:0][AW-1:0]  rd_addr,
    output logic [RP-1:0][PW-1:0]  rd_data,
    input  logic [W-1:0]           wr_en,
    input  logic [W-1:0][AW-1:0]   wr_addr,
    input  logic [W-1:0][PW-1:0]   wr_data,
    input  logic                   rec_en,
    input  logic [AW-1:0]          rec_addr,
    input  logic [PW-1:0]          rec_data
);

    logic [PW-1:0] mem [ARCH_N];

    // Read ports: a disabled port returns zero and does not sense the array.
    for (genvar p = 0; p < RP; p++) begin : g_rd
        assign rd_data[p] = rd_en[p] ? mem[rd_addr[p]] : '0;
    end

    // Writes in slot order; a younger slot overrides an older one on the
    // same entry. A restore owns the table for its cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_N; a++) begin
                mem[a] <= PW'(a);
            end
        end else if (rec_en) begin
            mem[rec_addr] <= rec_data;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (wr_en[i]) begin
                    mem[wr_addr[i]] <= wr_data[i];
                end
            end
        end
    end

endmodule

// File: rtl/rn_gate_count.sv
module rn_gate_count
    import rename_pkg::*;
#(
    parameter int N  = 2 * RN_WIDTH,
    parameter int CW = RN_CNT_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [N-1:0]  gated,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!hold) begin
            count <= count + CW'($countones(gated));
        end
    end

endmodule

// File: rtl/rename_stage.sv
module rename_stage
    import rename_pkg::*;
#(
    parameter int W      = RN_WIDTH,
    parameter int ARCH_N = RN_ARCH_REGS,
    parameter int PHYS_N = RN_PHYS_REGS,
    parameter int CW     = RN_CNT_BITS,
    localparam int AW = idx_bits(ARCH_N),
    localparam int PW = idx_bits(PHYS_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    inst_vld,
    input  logic [W-1:0]    src0_vld,
    input  logic [W-1:0]    src1_vld,
    input  logic [W-1:0]    dst_vld,
    input  logic [W*AW-1:0] src0_arch,
    input  logic [W*AW-1:0] src1_arch,
    input  logic [W*AW-1:0] dst_arch,
    input  logic [W*PW-1:0] free_tag,
    input  logic            rec_en,
    input  logic [AW-1:0]   rec_arch,
    input  logic [PW-1:0]   rec_tag,
    output logic [W*PW-1:0] src0_phys,
    output logic [W*PW-1:0] src1_phys,
    output logic [W*PW-1:0] old_phys,
    output logic            stall,
    output logic [CW-1:0]   gated_reads
);

    localparam int IW = idx_bits(W);
    localparam int RP = 3 * W;
    localparam int NOPS = 3;   // operand classes: src0, src1, dst

    // Per-slot unpacked views.
    logic [W-1:0][AW-1:0] s0_a, s1_a, d_a;
    logic [W-1:0][PW-1:0] tag;
    logic [W-1:0]         s0_use, s1_use, d_use;

    for (genvar i = 0; i < W; i++) begin : g_unpack
        assign s0_a[i]   = src0_arch[i*AW +: AW];
        assign s1_a[i]   = src1_arch[i*AW +: AW];
        assign d_a[i]    = dst_arch[i*AW +: AW];
        assign tag[i]    = free_tag[i*PW +: PW];
        assign s0_use[i] = inst_vld[i] & src0_vld[i];
        assign s1_use[i] = inst_vld[i] & src1_vld[i];
        assign d_use[i]  = inst_vld[i] & dst_vld[i];
    end

    // Operand class k: 0 = first source, 1 = second source, 2 = destination.
    logic [NOPS-1:0][W-1:0]          op_use;
    logic [NOPS-1:0][W-1:0][AW-1:0]  op_arch;
    logic [NOPS-1:0][W-1:0]          op_hit;
    logic [NOPS-1:0][W-1:0][IW-1:0]  op_idx;

    assign op_use  = {d_use, s1_use, s0_use};
    assign op_arch = {d_a, s1_a, s0_a};

    for (genvar k = 0; k < NOPS; k++) begin : g_dep
        rn_dep_check #(
            .W  (W),
            .AW (AW)
        ) u_dep (
            .prod_en   (d_use),
            .prod_arch (d_a),
            .cons_en   (op_use[k]),
            .cons_arch (op_arch[k]),
            .hit       (op_hit[k]),
            .prod_idx  (op_idx[k])
        );
    end

    // Alias table with 3W gated read ports and W write ports.
    logic [RP-1:0]          rd_en;
    logic [RP-1:0][AW-1:0]  rd_addr;
    logic [RP-1:0][PW-1:0]  rd_data;

    for (genvar k = 0; k < NOPS; k++) begin : g_port_k
        for (genvar i = 0; i < W; i++) begin : g_port_i
            assign rd_en[k*W + i]   = op_use[k][i] & ~op_hit[k][i];
            assign rd_addr[k*W + i] = op_arch[k][i];
        end
    end

    rn_map_table #(
        .W      (W),
        .ARCH_N (ARCH_N),
        .PHYS_N (PHYS_N)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (d_use),
        .wr_addr  (d_a),
        .wr_data  (tag),
        .rec_en   (rec_en),
        .rec_addr (rec_arch),
        .rec_data (rec_tag)
    );

    // Operand selection: forwarded tag, table value, or zero.
    opnd_src_e           op_sel  [NOPS][W];
    logic [NOPS-1:0][W-1:0][PW-1:0] op_phys;

    for (genvar k = 0; k < NOPS; k++) begin : g_sel_k
        for (genvar i = 0; i < W; i++) begin : g_sel_i
            always_comb begin
                if (!op_use[k][i]) begin
                    op_sel[k][i] = OPND_NONE;
                end else if (op_hit[k][i]) begin
                    op_sel[k][i] = OPND_FWD;
                end else begin
                    op_sel[k][i] = OPND_TABLE;
                end
                unique case (op_sel[k][i])
                    OPND_FWD:   op_phys[k][i] = tag[op_idx[k][i]];
                    OPND_TABLE: op_phys[k][i] = rd_data[k*W + i];
                    default:    op_phys[k][i] = '0;
                endcase
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign src0_phys[i*PW +: PW] = op_phys[0][i];
        assign src1_phys[i*PW +: PW] = op_phys[1][i];
        assign old_phys[i*PW +: PW]  = op_phys[2][i];
    end

    // Only source reads count as suppressed.
    rn_gate_count #(
        .N  (2 * W),
        .CW (CW)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .hold  (rec_en),
        .gated ({op_hit[1], op_hit[0]}),
        .count (gated_reads)
    );

    assign stall = rec_en;

endmodule

// File: rtl/rename_stage_chk.sv
module rename_stage_chk
    import rename_pkg::*;
#(
    parameter int W  = RN_WIDTH,
    parameter int AW = 5,
    parameter int PW = 7,
    parameter int CW = RN_CNT_BITS
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    inst_vld,
    input logic [W-1:0]    src0_vld,
    input logic [W-1:0]    dst_vld,
    input logic [W*AW-1:0] src0_arch,
    input logic [W*AW-1:0] dst_arch,
    input logic [W*PW-1:0] free_tag,
    input logic            rec_en,
    input logic [W*PW-1:0] src0_phys,
    input logic [W*PW-1:0] src1_phys,
    input logic [W*PW-1:0] old_phys,
    input logic [CW-1:0]   gated_reads
);

    // R4: at most 2W reads can be suppressed per cycle.
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        !rec_en |=> (gated_reads - $past(gated_reads)) <= CW'(2 * W));

    // R7: the counter does not move across a restore cycle.
    a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> gated_reads == $past(gated_reads));

    for (genvar i = 0; i < W; i++) begin : g_slot
        // R2: an idle slot reports zero on every operand output.
        a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
            !inst_vld[i] |-> (src0_phys[i*PW +: PW] == '0 &&
                              src1_phys[i*PW +: PW] == '0 &&
                              old_phys[i*PW +: PW]  == '0));
        if (i > 0) begin : g_pair
            // R3: the immediately older writer is always the nearest producer.
            a_r3_fwd_adjacent: assert property (@(posedge clk) disable iff (rst)
                (inst_vld[i] && src0_vld[i] && inst_vld[i-1] && dst_vld[i-1] &&
                 dst_arch[(i-1)*AW +: AW] == src0_arch[i*AW +: AW])
                |-> src0_phys[i*PW +: PW] == free_tag[(i-1)*PW +: PW]);
            // R5: same-destination chain checkpoints the older slot's new tag.
            a_r5_ckpt_adjacent: assert property (@(posedge clk) disable iff (rst)
                (inst_vld[i] && dst_vld[i] && inst_vld[i-1] && dst_vld[i-1] &&
                 dst_arch[(i-1)*AW +: AW] == dst_arch[i*AW +: AW])
                |-> old_phys[i*PW +: PW] == free_tag[(i-1)*PW +: PW]);
        end
    end

endmodule

bind rename_stage rename_stage_chk #(
    .W  (W),
    .AW (AW),
    .PW (PW),
    .CW (CW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .inst_vld    (inst_vld),
    .src0_vld    (src0_vld),
    .dst_vld     (dst_vld),
    .src0_arch   (src0_arch),
    .dst_arch    (dst_arch),
    .free_tag    (free_tag),
    .rec_en      (rec_en),
    .src0_phys   (src0_phys),
    .src1_phys   (src1_phys),
    .old_phys    (old_phys),
    .gated_reads (gated_reads)
);

// File: tb/rename_stage_tb.sv
module rename_stage_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int AW = 5;
    localparam int PW = 7;
    localparam int NV = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [W-1:0]    inst_vld, src0_vld, src1_vld, dst_vld;
    logic [W*AW-1:0] src0_arch, src1_arch, dst_arch;
    logic [W*PW-1:0] free_tag;
    logic            rec_en;
    logic [AW-1:0]   rec_arch;
    logic [PW-1:0]   rec_tag;
    logic [W*PW-1:0] src0_phys, src1_phys, old_phys;
    logic            stall;
    logic [31:0]     gated_reads;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rename_stage dut_i (
        .clk(clk), .rst(rst),
        .inst_vld(inst_vld), .src0_vld(src0_vld), .src1_vld(src1_vld), .dst_vld(dst_vld),
        .src0_arch(src0_arch), .src1_arch(src1_arch), .dst_arch(dst_arch),
        .free_tag(free_tag), .rec_en(rec_en), .rec_arch(rec_arch), .rec_tag(rec_tag),
        .src0_phys(src0_phys), .src1_phys(src1_phys), .old_phys(old_phys),
        .stall(stall), .gated_reads(gated_reads)
    );

    // Vector table, one row per rename group, slot 0 first.
    localparam int IV  [NV][W] = '{'{1,1,1,1}, '{1,1,1,1}, '{1,0,1,1}, '{1,1,1,1}};
    localparam int S0V [NV][W] = '{'{1,1,1,1}, '{1,1,1,1}, '{1,1,1,1}, '{1,1,1,1}};
    localparam int S1V [NV][W] = '{'{1,1,1,1}, '{1,1,1,1}, '{0,1,1,0}, '{1,1,1,1}};
    localparam int DV  [NV][W] = '{'{1,1,1,1}, '{1,1,1,1}, '{0,1,1,1}, '{1,1,1,1}};
    localparam int S0  [NV][W] = '{'{1,3,5,7}, '{10,20,20,21}, '{20,21,22,22}, '{21,23,20,30}};
    localparam int S1  [NV][W] = '{'{2,4,6,8}, '{11,12,20,13}, '{9,0,21,22}, '{22,9,10,31}};
    localparam int DA  [NV][W] = '{'{10,11,12,13}, '{20,20,21,20}, '{21,22,22,23}, '{30,31,30,0}};
    localparam int TG  [NV][W] = '{'{100,101,102,103}, '{104,105,106,107},
                                   '{108,109,110,111}, '{112,113,114,115}};
    localparam int E0  [NV][W] = '{'{1,3,5,7}, '{100,104,105,106},
                                   '{107,0,22,110}, '{106,111,107,114}};
    localparam int E1  [NV][W] = '{'{2,4,6,8}, '{101,102,105,103},
                                   '{0,0,106,0}, '{110,9,100,113}};
    localparam int EO  [NV][W] = '{'{10,11,12,13}, '{20,104,21,105},
                                   '{0,0,22,23}, '{30,31,112,0}};
    localparam int ECNT [NV]   = '{0, 4, 5, 7};
    localparam string VREQ [NV] = '{"R2", "R3", "R8", "R6"};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        inst_vld = '0; src0_vld = '0; src1_vld = '0; dst_vld = '0;
        src0_arch = '0; src1_arch = '0; dst_arch = '0; free_tag = '0;
        rec_en = 1'b0; rec_arch = '0; rec_tag = '0;
    endtask

    task automatic set_slot(input int i, input bit v, input bit v0, input bit v1, input bit vd,
                            input int a0, input int a1, input int ad, input int t);
        inst_vld[i] = v; src0_vld[i] = v0; src1_vld[i] = v1; dst_vld[i] = vd;
        src0_arch[i*AW +: AW] = AW'(a0);
        src1_arch[i*AW +: AW] = AW'(a1);
        dst_arch[i*AW +: AW]  = AW'(ad);
        free_tag[i*PW +: PW]  = PW'(t);
    endtask

    function automatic logic [31:0] slot_of(input logic [W*PW-1:0] bus, input int i);
        return 32'(bus[i*PW +: PW]);
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "counter after reset", gated_reads, 0);
        check("R1", "stall after reset", 32'(stall), 0);
        set_slot(0, 1, 1, 1, 0, 31, 17, 0, 0);
        #1;
        check("R1", "entry 31 identity", slot_of(src0_phys, 0), 31);
        check("R1", "entry 17 identity", slot_of(src1_phys, 0), 17);

        // Vector walk: apply group, check combinational outputs, then counter.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            idle_inputs();
            for (int i = 0; i < W; i++) begin
                set_slot(i, IV[v][i] != 0, S0V[v][i] != 0, S1V[v][i] != 0, DV[v][i] != 0,
                         S0[v][i], S1[v][i], DA[v][i], TG[v][i]);
            end
            #1;
            for (int i = 0; i < W; i++) begin
                check(VREQ[v], $sformatf("vec %0d slot %0d src0", v, i),
                      slot_of(src0_phys, i), 32'(E0[v][i]));
                check(VREQ[v], $sformatf("vec %0d slot %0d src1 (R2/R3)", v, i),
                      slot_of(src1_phys, i), 32'(E1[v][i]));
                check("R5", $sformatf("vec %0d slot %0d checkpoint", v, i),
                      slot_of(old_phys, i), 32'(EO[v][i]));
            end
            @(posedge clk);
            #1;
            check("R4", $sformatf("vec %0d counter", v), gated_reads, 32'(ECNT[v]));
        end

        // R7: restore with a competing rename group in the same cycle.
        @(negedge clk);
        idle_inputs();
        rec_en = 1'b1; rec_arch = 5'd30; rec_tag = 7'd112;
        set_slot(0, 1, 0, 0, 1, 0, 0, 30, 120);
        set_slot(1, 1, 1, 0, 1, 30, 0, 5, 121);
        #1;
        check("R7", "stall during restore", 32'(stall), 1);
        @(posedge clk);
        #1;
        check("R7", "counter held by restore", gated_reads, 7);
        @(negedge clk);
        idle_inputs();
        set_slot(0, 1, 1, 1, 0, 30, 0, 0, 0);
        set_slot(1, 1, 1, 0, 0, 5, 0, 0, 0);
        #1;
        check("R7", "stall released", 32'(stall), 0);
        check("R7", "restored entry 30", slot_of(src0_phys, 0), 112);
        check("R6", "entry 0 from youngest-slot write", slot_of(src1_phys, 0), 115);
        check("R7", "rename during restore not written", slot_of(src0_phys, 1), 5);

        // R6: entry 31 kept from vector 3, entry 21 untouched by invalid slots
        @(negedge clk);
        idle_inputs();
        set_slot(0, 1, 1, 1, 0, 31, 21, 0, 0);
        #1;
        check("R6", "entry 31", slot_of(src0_phys, 0), 113);
        check("R8", "entry 21 untouched by invalid writers", slot_of(src1_phys, 0), 106);

        // R1: reset mid-run restores identity mapping and clears the counter.
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        set_slot(0, 1, 1, 1, 0, 30, 0, 0, 0);
        #1;
        check("R1", "counter cleared", gated_reads, 0);
        check("R1", "entry 30 identity", slot_of(src0_phys, 0), 30);
        check("R1", "entry 0 identity", slot_of(src1_phys, 0), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule